// File: doc/BRIEF.md
# SDRAM bank state and timing tracker

This block follows the command stream that an SDRAM controller issues to a four-bank device. It records whether each bank is open and which row it holds, and it keeps elapsed-cycle counters for every bank-level timing rule. From these it reports, on every cycle, which commands would be legal to which bank. The controller samples these flags before it issues a command, so it needs no timing logic of its own.

All timing values enter as cycle counts on input ports and are held constant between resets. A command that breaks a rule is not applied. Instead a one-cycle error pulse follows it. Auto-precharge is modelled internally: the tracker works out the cycle in which the implicit precharge starts and closes the bank there on its own.

Distances are counted in cycles. A command in cycle c and a later command in cycle c+k are k cycles apart. All timing inputs are at least 1, at most 63, and the counters saturate at 63.

Top module: `sdram_bank_tracker`

## Requirements
- R1: An activate (cmd_op=1) to bank b is legal only when all of the following hold: the bank is closed; at least t_rc cycles separate it from the bank's previous activate; at least t_rp cycles separate it from the bank's last precharge; and at least t_rrd cycles separate it from the last activate to any bank. An accepted activate opens the bank and stores cmd_row in bank_row[b*ROW_W +: ROW_W].
- R2: A read (cmd_op=2) or write (cmd_op=3) to bank b is legal only when the bank is open, at least t_rcd cycles have passed since its activate, and no auto-precharge is pending on it.
- R3: A single-bank precharge (cmd_op=4, cmd_a10=0) is legal when the selected bank has no pending auto-precharge and is either closed or has been open for at least t_ras cycles. It closes an open bank and starts that bank's t_rp window. It leaves a closed bank unchanged.
- R4: A precharge with cmd_a10=1 is legal only when every open bank has met t_ras and no bank has a pending auto-precharge. It closes all open banks.
- R5: A write with cmd_a10=1 issued in cycle c closes its bank at the edge that ends cycle c+D. Here D is the larger of burst_len-1+t_wr and the cycles still missing to t_ras. The bank can therefore be activated again t_rp cycles later, which is t_wr+t_rp after the last data beat.
- R6: A read with cmd_a10=1 issued in cycle c closes its bank at the edge that ends cycle c+D. Here D is the larger of burst_len and the cycles still missing to t_ras.
- R7: While an auto-precharge is pending on a bank, ap_pending is high for that bank, and reads, writes and precharges to it are illegal.
- R8: A read or write with cmd_a10=1 while full_page is high is illegal.
- R9: Refresh (cmd_op=5) and mode-register set (cmd_op=6) are legal only when every bank is closed and has met t_rp. legal_all_idle reports exactly this condition.
- R10: A command presented with cmd_valid high and found illegal changes no bank state. cmd_err is high in the following cycle, and only then.
- R11: After reset all banks are closed, all rows read 0, no auto-precharge is pending, cmd_err is low, and activates are legal to every bank.
- R12: Code 0 is no-operation and is always legal. Code 7 is reserved and is always flagged illegal. With cmd_valid low, no command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | 2 | Target bank |
| cmd_row | input | ROW_W | Row for an activate |
| cmd_a10 | input | 1 | Auto-precharge for read/write, all-banks for precharge |
| t_rcd | input | CNT_W | Activate to read/write, cycles |
| t_rc | input | CNT_W | Activate to activate, same bank |
| t_rrd | input | CNT_W | Activate to activate, any bank |
| t_rp | input | CNT_W | Precharge to activate |
| t_ras | input | CNT_W | Activate to precharge minimum |
| t_wr | input | CNT_W | Write recovery |
| burst_len | input | CNT_W | Burst length in beats |
| full_page | input | 1 | Full-page bursts are configured |
| legal_act | output | NB | Activate would be legal, per bank |
| legal_rw | output | NB | Read/write would be legal, per bank |
| legal_pre | output | NB | Single-bank precharge would be legal, per bank |
| legal_all_idle | output | 1 | Refresh / mode set would be legal |
| bank_active | output | NB | Bank is open |
| bank_row | output | NB*ROW_W | Open row per bank |
| ap_pending | output | NB | Auto-precharge scheduled, per bank |
| cmd_err | output | 1 | Previous cycle's command was illegal |

## Verification
The assertions assume that the timing inputs and full_page stay fixed while rst_n is high, that each timing input lies between 1 and 63, and that cmd_bank and cmd_op are never unknown. The bench meets these assumptions by changing the timing configuration only while reset is held, and by drawing every value from a table of small legal counts. Within each configuration, the commands are pseudo-random with no filtering, so many of them are deliberately illegal. The error path and the unchanged-state rule are therefore exercised as often as the accepted paths.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_MRS = 3'd6,
    OP_RSV = 3'd7
  } trk_op_e;

  // Cycles from a read/write-with-auto-precharge command to the cycle in
  // which the implicit precharge takes effect.
  function automatic int unsigned ap_lead(input bit is_wr,
                                          input int unsigned bl,
                                          input int unsigned twr,
                                          input int unsigned tras,
                                          input int unsigned open_for);
    int unsigned burst_part;
    int unsigned ras_part;
    burst_part = is_wr ? (bl + twr - 1) : bl;
    ras_part   = (tras > open_for) ? (tras - open_for) : 0;
    return (burst_part > ras_part) ? burst_part : ras_part;
  endfunction

  function automatic bit window_met(input int unsigned elapsed,
                                    input int unsigned need);
    return elapsed >= need;
  endfunction

endpackage

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
  import sdram_trk_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] t_rcd,
  input  logic [CNT_W-1:0] t_rc,
  input  logic [CNT_W-1:0] t_rp,
  input  logic [CNT_W-1:0] t_ras,
  input  logic [CNT_W-1:0] t_wr,
  input  logic [CNT_W-1:0] burst_len,
  input  logic             rrd_ok,
  input  logic             act_go,
  input  logic             rw_go,
  input  logic             rw_is_wr,
  input  logic             rw_ap,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] new_row,
  output logic             act_ok,
  output logic             rw_ok,
  output logic             pre_ok,
  output logic             idle_ready,
  output logic             active,
  output logic [ROW_W-1:0] row,
  output logic             ap_busy,
  output logic             ap_fire
);

  localparam int LEFT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  since_act;
  logic [CNT_W-1:0]  since_pre;
  logic [LEFT_W-1:0] ap_left;
  int unsigned       lead;

  assign lead = ap_lead(rw_is_wr, 32'(burst_len), 32'(t_wr),
                        32'(t_ras), 32'(since_act));

  assign ap_fire    = ap_busy && (ap_left == '0);
  assign act_ok     = !active
                      && window_met(32'(since_act), 32'(t_rc))
                      && window_met(32'(since_pre), 32'(t_rp))
                      && rrd_ok;
  assign rw_ok      = active && !ap_busy
                      && window_met(32'(since_act), 32'(t_rcd));
  assign pre_ok     = !ap_busy
                      && (!active || window_met(32'(since_act), 32'(t_ras)));
  assign idle_ready = !active && window_met(32'(since_pre), 32'(t_rp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      row       <= '0;
      since_act <= SAT;
      since_pre <= SAT;
      ap_busy   <= 1'b0;
      ap_left   <= '0;
    end else begin
      if (since_act != SAT) since_act <= since_act + CNT_W'(1);
      if (since_pre != SAT) since_pre <= since_pre + CNT_W'(1);

      if (act_go) begin
        active    <= 1'b1;
        row       <= new_row;
        since_act <= CNT_W'(1);
      end

      if (pre_go && active) begin
        active    <= 1'b0;
        since_pre <= CNT_W'(1);
      end

      if (rw_go && rw_ap) begin
        ap_busy <= 1'b1;
        ap_left <= LEFT_W'(lead - 1);
      end

      if (ap_busy) begin
        if (ap_fire) begin
          ap_busy   <= 1'b0;
          active    <= 1'b0;
          since_pre <= CNT_W'(1);
        end else begin
          ap_left <= ap_left - LEFT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
#(
  parameter int NB     = 4,
  parameter int BANK_W = 2
) (
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_a10,
  input  logic              full_page,
  input  logic [NB-1:0]     act_ok,
  input  logic [NB-1:0]     rw_ok,
  input  logic [NB-1:0]     pre_ok,
  input  logic              all_ready,
  output logic [NB-1:0]     act_go,
  output logic [NB-1:0]     rw_go,
  output logic [NB-1:0]     pre_go,
  output logic              rw_is_wr,
  output logic              rw_ap,
  output logic              any_act,
  output logic              err_now
);

  trk_op_e     op;
  logic [NB-1:0] sel;
  logic        legal;

  assign op       = trk_op_e'(cmd_op);
  assign sel      = NB'(1) << cmd_bank;
  assign rw_is_wr = (op == OP_WR);
  assign rw_ap    = cmd_a10;
  assign any_act  = |act_go;
  assign err_now  = cmd_valid && !legal;

  always_comb begin
    legal  = 1'b1;
    act_go = '0;
    rw_go  = '0;
    pre_go = '0;
    if (cmd_valid) begin
      case (op)
        OP_NOP: legal = 1'b1;
        OP_ACT: begin
          legal  = act_ok[cmd_bank];
          act_go = legal ? sel : '0;
        end
        OP_RD, OP_WR: begin
          legal = rw_ok[cmd_bank] && !(cmd_a10 && full_page);
          rw_go = legal ? sel : '0;
        end
        OP_PRE: begin
          if (cmd_a10) begin
            legal  = &pre_ok;
            pre_go = legal ? {NB{1'b1}} : '0;
          end else begin
            legal  = pre_ok[cmd_bank];
            pre_go = legal ? sel : '0;
          end
        end
        OP_REF, OP_MRS: legal = all_ready;
        default: legal = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NB    = 4,
  parameter int ROW_W = 11,
  parameter int CNT_W = 6,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [BANK_W-1:0]   cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  input  logic                cmd_a10,
  input  logic [CNT_W-1:0]    t_rcd,
  input  logic [CNT_W-1:0]    t_rc,
  input  logic [CNT_W-1:0]    t_rrd,
  input  logic [CNT_W-1:0]    t_rp,
  input  logic [CNT_W-1:0]    t_ras,
  input  logic [CNT_W-1:0]    t_wr,
  input  logic [CNT_W-1:0]    burst_len,
  input  logic                full_page,
  output logic [NB-1:0]       legal_act,
  output logic [NB-1:0]       legal_rw,
  output logic [NB-1:0]       legal_pre,
  output logic                legal_all_idle,
  output logic [NB-1:0]       bank_active,
  output logic [NB*ROW_W-1:0] bank_row,
  output logic [NB-1:0]       ap_pending,
  output logic                cmd_err
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [NB-1:0]    act_go, rw_go, pre_go, idle_ready, ap_fire;
  logic             rw_is_wr, rw_ap, any_act, err_now, rrd_ok;
  logic [CNT_W-1:0] since_any_act;

  assign rrd_ok         = since_any_act >= t_rrd;
  assign legal_all_idle = &idle_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any_act <= SAT;
      cmd_err       <= 1'b0;
    end else begin
      cmd_err <= err_now;
      if (any_act) since_any_act <= CNT_W'(1);
      else if (since_any_act != SAT) since_any_act <= since_any_act + CNT_W'(1);
    end
  end

  sdram_cmd_decode #(.NB(NB), .BANK_W(BANK_W)) u_decode (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_a10   (cmd_a10),
    .full_page (full_page),
    .act_ok    (legal_act),
    .rw_ok     (legal_rw),
    .pre_ok    (legal_pre),
    .all_ready (legal_all_idle),
    .act_go    (act_go),
    .rw_go     (rw_go),
    .pre_go    (pre_go),
    .rw_is_wr  (rw_is_wr),
    .rw_ap     (rw_ap),
    .any_act   (any_act),
    .err_now   (err_now)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .t_rcd      (t_rcd),
      .t_rc       (t_rc),
      .t_rp       (t_rp),
      .t_ras      (t_ras),
      .t_wr       (t_wr),
      .burst_len  (burst_len),
      .rrd_ok     (rrd_ok),
      .act_go     (act_go[b]),
      .rw_go      (rw_go[b]),
      .rw_is_wr   (rw_is_wr),
      .rw_ap      (rw_ap),
      .pre_go     (pre_go[b]),
      .new_row    (cmd_row),
      .act_ok     (legal_act[b]),
      .rw_ok      (legal_rw[b]),
      .pre_ok     (legal_pre[b]),
      .idle_ready (idle_ready[b]),
      .active     (bank_active[b]),
      .row        (bank_row[b*ROW_W +: ROW_W]),
      .ap_busy    (ap_pending[b]),
      .ap_fire    (ap_fire[b])
    );
  end

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 11,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [2:0]          cmd_op,
  input logic [BANK_W-1:0]   cmd_bank,
  input logic                cmd_a10,
  input logic [NB-1:0]       legal_act,
  input logic [NB-1:0]       legal_rw,
  input logic [NB-1:0]       legal_pre,
  input logic                legal_all_idle,
  input logic [NB-1:0]       bank_active,
  input logic [NB*ROW_W-1:0] bank_row,
  input logic [NB-1:0]       ap_pending,
  input logic                cmd_err,
  input logic                err_now,
  input logic [NB-1:0]       ap_fire
);

  for (genvar b = 0; b < NB; b++) begin : g_per_bank
    assert_act_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ACT && cmd_bank == BANK_W'(b) && legal_act[b])
      |=> bank_active[b]);

    assert_rw_needs_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      legal_rw[b] |-> bank_active[b]);

    assert_ap_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ap_pending[b] |-> (!legal_rw[b] && !legal_pre[b]));

    assert_ap_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ap_fire[b] |=> !bank_active[b]);
  end

  assert_bad_act_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT && !legal_act[cmd_bank]) |=> cmd_err);

  assert_prea_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PRE && cmd_a10 && !err_now) |=> (bank_active == '0));

  assert_all_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    legal_all_idle |-> (bank_active == '0));

  assert_err_keeps_rows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> $stable(bank_row));

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> cmd_err);

  assert_no_spurious_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_now |=> !cmd_err);

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(.NB(NB), .ROW_W(ROW_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_op         (cmd_op),
  .cmd_bank       (cmd_bank),
  .cmd_a10        (cmd_a10),
  .legal_act      (legal_act),
  .legal_rw       (legal_rw),
  .legal_pre      (legal_pre),
  .legal_all_idle (legal_all_idle),
  .bank_active    (bank_active),
  .bank_row       (bank_row),
  .ap_pending     (ap_pending),
  .cmd_err        (cmd_err),
  .err_now        (err_now),
  .ap_fire        (ap_fire)
);

// File: tb/sdram_bank_tracker_bench.sv
`timescale 1ns/1ps
module sdram_bank_tracker_bench;

  localparam int NB    = 4;
  localparam int ROW_W = 11;
  localparam int CNT_W = 6;
  localparam int STEPS = 2000;
  localparam int NCFG  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_bank = '0;
  logic [ROW_W-1:0] cmd_row = '0;
  logic cmd_a10 = 1'b0;
  logic [CNT_W-1:0] t_rcd, t_rc, t_rrd, t_rp, t_ras, t_wr, burst_len;
  logic full_page;
  logic [NB-1:0] legal_act, legal_rw, legal_pre, bank_active, ap_pending;
  logic legal_all_idle, cmd_err;
  logic [NB*ROW_W-1:0] bank_row;

  always #10 clk = ~clk;

  sdram_bank_tracker #(.NB(NB), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_sdram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_a10(cmd_a10),
    .t_rcd(t_rcd), .t_rc(t_rc), .t_rrd(t_rrd), .t_rp(t_rp), .t_ras(t_ras),
    .t_wr(t_wr), .burst_len(burst_len), .full_page(full_page),
    .legal_act(legal_act), .legal_rw(legal_rw), .legal_pre(legal_pre),
    .legal_all_idle(legal_all_idle), .bank_active(bank_active),
    .bank_row(bank_row), .ap_pending(ap_pending), .cmd_err(cmd_err)
  );

  int checks = 0;
  int fails  = 0;

  // timing configuration
  int c_rcd, c_rc, c_rrd, c_rp, c_ras, c_wr, c_bl, c_fp;

  // reference state, plain integers
  int m_open[NB], m_row[NB], m_sa[NB], m_sp[NB], m_ap[NB], m_fire[NB], m_apwr[NB];
  int m_fired[NB];
  int m_srr, m_err, cyc;
  int exp_prea, exp_fp_err, exp_rsv_err;
  int v_i, op_i, b_i, a10_i, row_i;
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic load_cfg(input int k);
    case (k)
      0: begin c_rcd=2; c_rc=6;  c_rrd=2; c_rp=2; c_ras=4; c_wr=2; c_bl=4; c_fp=0; end
      1: begin c_rcd=1; c_rc=3;  c_rrd=1; c_rp=1; c_ras=2; c_wr=1; c_bl=1; c_fp=0; end
      2: begin c_rcd=3; c_rc=9;  c_rrd=3; c_rp=2; c_ras=8; c_wr=2; c_bl=2; c_fp=0; end
      3: begin c_rcd=2; c_rc=5;  c_rrd=1; c_rp=3; c_ras=3; c_wr=3; c_bl=8; c_fp=1; end
      default: begin c_rcd=4; c_rc=10; c_rrd=2; c_rp=1; c_ras=6; c_wr=1; c_bl=4; c_fp=0; end
    endcase
    t_rcd = 6'(c_rcd); t_rc = 6'(c_rc); t_rrd = 6'(c_rrd); t_rp = 6'(c_rp);
    t_ras = 6'(c_ras); t_wr = 6'(c_wr); burst_len = 6'(c_bl); full_page = c_fp[0];
  endtask

  function automatic bit e_act(input int b);
    return m_open[b] == 0 && m_sa[b] >= c_rc && m_sp[b] >= c_rp && m_srr >= c_rrd;
  endfunction
  function automatic bit e_rw(input int b);
    return m_open[b] == 1 && m_ap[b] == 0 && m_sa[b] >= c_rcd;
  endfunction
  function automatic bit e_pre(input int b);
    return m_ap[b] == 0 && (m_open[b] == 0 || m_sa[b] >= c_ras);
  endfunction
  function automatic bit e_all();
    bit r = 1'b1;
    for (int b = 0; b < NB; b++)
      if (m_open[b] != 0 || m_sp[b] < c_rp) r = 1'b0;
    return r;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_sa[b] = 1000; m_sp[b] = 1000;
      m_ap[b] = 0; m_fire[b] = 0; m_apwr[b] = 0; m_fired[b] = 0;
    end
    m_srr = 1000; m_err = 0; exp_prea = 0; exp_fp_err = 0; exp_rsv_err = 0;
  endtask

  task automatic compare();
    for (int b = 0; b < NB; b++) begin
      chk(bank_active[b] == m_open[b][0], "R1", "bank_active", bank_active[b], m_open[b]);
      chk(int'(bank_row[b*ROW_W +: ROW_W]) == m_row[b], "R1", "bank_row",
          int'(bank_row[b*ROW_W +: ROW_W]), m_row[b]);
      chk(legal_act[b] == e_act(b), "R1", "legal_act", legal_act[b], e_act(b));
      chk(legal_rw[b] == e_rw(b), "R2", "legal_rw", legal_rw[b], e_rw(b));
      chk(legal_pre[b] == e_pre(b), "R3", "legal_pre", legal_pre[b], e_pre(b));
      chk(ap_pending[b] == m_ap[b][0], "R7", "ap_pending", ap_pending[b], m_ap[b]);
      if (m_fired[b] != 0) begin
        if (m_apwr[b] != 0)
          chk(bank_active[b] == 1'b0, "R5", "closed after write auto-precharge", bank_active[b], 0);
        else
          chk(bank_active[b] == 1'b0, "R6", "closed after read auto-precharge", bank_active[b], 0);
      end
    end
    chk(legal_all_idle == e_all(), "R9", "legal_all_idle", legal_all_idle, e_all());
    chk(cmd_err == m_err[0], "R10", "cmd_err", cmd_err, m_err);
    if (exp_prea != 0) chk(bank_active == '0, "R4", "all closed after precharge-all", bank_active, 0);
    if (exp_fp_err != 0) chk(cmd_err == 1'b1, "R8", "auto-precharge with full page", cmd_err, 1);
    if (exp_rsv_err != 0) chk(cmd_err == 1'b1, "R12", "reserved code", cmd_err, 1);
  endtask

  // Applies the command presented in cycle cyc to the reference state.
  task automatic model_step();
    bit lg;
    int sa_now, d, burst_part, ras_part;
    lg = 1'b1;
    if (v_i != 0) begin
      case (op_i)
        0: lg = 1'b1;
        1: lg = e_act(b_i);
        2, 3: lg = e_rw(b_i) && !(a10_i != 0 && c_fp != 0);
        4: begin
          if (a10_i != 0) begin
            lg = 1'b1;
            for (int b = 0; b < NB; b++) if (!e_pre(b)) lg = 1'b0;
          end else lg = e_pre(b_i);
        end
        5, 6: lg = e_all();
        default: lg = 1'b0;
      endcase
    end
    sa_now = m_sa[b_i];
    m_err = (v_i != 0 && !lg) ? 1 : 0;
    exp_prea    = (v_i != 0 && lg && op_i == 4 && a10_i != 0) ? 1 : 0;
    exp_fp_err  = (v_i != 0 && (op_i == 2 || op_i == 3) && a10_i != 0 && c_fp != 0) ? 1 : 0;
    exp_rsv_err = (v_i != 0 && op_i == 7) ? 1 : 0;
    for (int b = 0; b < NB; b++) begin
      m_sa[b]++; m_sp[b]++; m_fired[b] = 0;
      if (m_ap[b] != 0 && m_fire[b] == cyc) begin
        m_ap[b] = 0; m_open[b] = 0; m_sp[b] = 1; m_fired[b] = 1;
      end
    end
    m_srr++;
    if (v_i != 0 && lg) begin
      case (op_i)
        1: begin m_open[b_i] = 1; m_row[b_i] = row_i; m_sa[b_i] = 1; m_srr = 1; end
        2, 3: if (a10_i != 0) begin
          burst_part = (op_i == 3) ? c_bl - 1 + c_wr : c_bl;
          ras_part   = c_ras - sa_now;
          d = (burst_part > ras_part) ? burst_part : ras_part;
          m_ap[b_i] = 1; m_fire[b_i] = cyc + d; m_apwr[b_i] = (op_i == 3) ? 1 : 0;
        end
        4: begin
          for (int b = 0; b < NB; b++)
            if ((a10_i != 0 || b == b_i) && m_open[b] != 0) begin
              m_open[b] = 0; m_sp[b] = 1;
            end
        end
        default: ;
      endcase
    end
    cyc++;
  endtask

  initial begin : watchdog
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stimulus
    for (int k = 0; k < NCFG; k++) begin
      load_cfg(k);
      rst_n = 1'b0; cmd_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      cyc = 0;
      // R11: state right after reset
      chk(bank_active == '0 && ap_pending == '0 && !cmd_err && bank_row == '0,
          "R11", "reset state", int'(bank_active), 0);
      chk(legal_act == '1, "R11", "activates legal after reset", int'(legal_act), 15);
      for (int n = 0; n < STEPS; n++) begin
        compare();
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
        v_i   = (lfsr[1:0] != 2'b00) ? 1 : 0;
        op_i  = int'(lfsr[4:2]);
        b_i   = int'(lfsr[6:5]);
        a10_i = (lfsr[9:7] == 3'b000) ? 1 : 0;
        row_i = int'(lfsr[20:10]);
        cmd_valid = v_i[0]; cmd_op = 3'(op_i); cmd_bank = 2'(b_i);
        cmd_a10 = a10_i[0]; cmd_row = ROW_W'(row_i);
        @(posedge clk);
        model_step();
        @(negedge clk);
      end
      compare();
      cmd_valid = 1'b0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule